// File: doc/BRIEF.md
# Transfer Count Register Set

This block holds the programmable byte count for a storage controller's data transfers. The host writes the count one byte at a time into shadow registers. The count the rest of the controller sees, and the host reads back, changes only when a command arrives with its DMA bit set. At that point all shadow bytes move into the live count together. A count of zero stands for 65536 bytes. When a transfer command starts, the block reports the length to move. That length is the effective count, capped by the data still outstanding, or by 32 while command bytes are being collected.

The block also keeps a terminal-count status flag. Completion of a DMA transfer sets it, and three events clear it: a count write, a read of the interrupt cause, and the start of a transfer command. Until the host has written the top count byte once after reset, reading that byte's address returns a fixed identification value. A soft reset command returns every register and flag to its power-up state.

Top module: `xfer_count_regs`

## Requirements
- R1: After reset the live count reads zero on every byte, term_count and dma_mode are low, and select 2 returns the chip identification byte (default 0x12).
- R2: A write on wr_sel 0, 1 or 2 (low, middle, high byte) only updates the shadow byte. The live count read on rd_sel keeps its value until a load. A write on select 3 is ignored.
- R3: Every command with cmd_dma high copies all shadow bytes into the live count and sets dma_mode. A command with cmd_dma low leaves the count unchanged and clears dma_mode.
- R4: The effective count is low | middle<<8 | high<<16. When all three bytes are zero it is 0x10000.
- R5: A transfer command (cmd_op 1) produces xfer_len with xfer_len_valid high for exactly one cycle after the command edge. xfer_len is the smaller of the effective count and remain, or the smaller of the count and 32 when collect_mode is high. If cmd_dma is set on that command, the freshly loaded shadow count is used.
- R6: A write to any of the three count bytes clears term_count.
- R7: dma_done clears the live count to zero and sets term_count. A set in the same cycle as a clear wins.
- R8: A cause_rd pulse clears term_count, and so does the start of a transfer command.
- R9: Select 2 reads the chip identification byte until the high count byte has been written once. After that it reads the live high count byte.
- R10: A soft reset command (cmd_op 2) clears the shadow bytes, the live count, dma_mode, term_count and the high-byte-written flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Host register write strobe |
| wr_sel | input | 2 | Byte select for writes: 0 low, 1 middle, 2 high, 3 none |
| wr_data | input | 8 | Write data |
| rd_sel | input | 2 | Byte select for reads: 0 low, 1 middle, 2 high or ID |
| rd_data | output | 8 | Read data (combinational from registers) |
| cmd_valid | input | 1 | Command issue strobe |
| cmd_op | input | 2 | Command class: 0 other, 1 transfer, 2 soft reset |
| cmd_dma | input | 1 | DMA bit of the issued command |
| dma_done | input | 1 | DMA transfer finished pulse |
| cause_rd | input | 1 | Host read of the interrupt cause register |
| collect_mode | input | 1 | Command bytes are being collected |
| remain | input | 24 | Data bytes still outstanding |
| xfer_len | output | 24 | Length chosen for the transfer |
| xfer_len_valid | output | 1 | One-cycle strobe qualifying xfer_len |
| term_count | output | 1 | Terminal-count status flag |
| dma_mode | output | 1 | The last command carried the DMA bit |

## Verification
Transfer lengths are tried with a count smaller than remain and with one larger, so a swapped minimum shows up. A count placed only in the high byte catches a wrong byte position, and an all-zero count must yield 0x10000 rather than zero. Collect mode against a large count shows that the 32 cap replaces remain. A DMA transfer command issued right after new shadow writes tells apart using the fresh shadow count from using the stale live count. Term_count is set and then cleared by each of its three clearing events, plus a same-cycle set and clear, which separates the clear sources and the priority between them.

// File: rtl/tcnt_pkg.sv
package tcnt_pkg;

    // Command classes seen by the count block
    typedef enum logic [1:0] {
        OP_MISC = 2'd0,
        OP_XFER = 2'd1,
        OP_SRST = 2'd2,
        OP_RSVD = 2'd3
    } cmd_op_e;

endpackage

// File: rtl/tcnt_shadow.sv
module tcnt_shadow #(
    parameter int NBYTES = 3,
    parameter int BYTE_W = 8,
    parameter int SEL_W  = 2
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             soft_rst,
    input  logic                             wr_en,
    input  logic [SEL_W-1:0]                 wr_sel,
    input  logic [BYTE_W-1:0]                wr_data,
    output logic [NBYTES-1:0][BYTE_W-1:0]    shadow,
    output logic                             hi_written
);

    localparam logic [SEL_W-1:0] HI_SEL = SEL_W'(NBYTES - 1);

    typedef struct packed {
        logic [NBYTES-1:0][BYTE_W-1:0] sh;
        logic                          hi_wr;
    } state_t;

    state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            for (int i = 0; i < NBYTES; i++) begin
                if (wr_sel == SEL_W'(i)) begin
                    st_d.sh[i] = wr_data;
                end
            end
            if (wr_sel == HI_SEL) begin
                st_d.hi_wr = 1'b1;
            end
        end
        if (soft_rst) begin
            st_d = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign shadow     = st_q.sh;
    assign hi_written = st_q.hi_wr;

    // R9
    hi_flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel == HI_SEL && !soft_rst) |=> hi_written);

    // R10
    srst_clears_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |=> !hi_written);

endmodule

// File: rtl/tcnt_count.sv
module tcnt_count #(
    parameter int NBYTES = 3,
    parameter int BYTE_W = 8
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          soft_rst,
    input  logic                          cmd_valid,
    input  logic                          cmd_dma,
    input  logic                          dma_done,
    input  logic [NBYTES-1:0][BYTE_W-1:0] shadow,
    output logic [NBYTES-1:0][BYTE_W-1:0] count,
    output logic                          dma_mode
);

    typedef struct packed {
        logic [NBYTES-1:0][BYTE_W-1:0] cnt;
        logic                          dma;
    } state_t;

    state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (cmd_valid) begin
            st_d.dma = cmd_dma;
            if (cmd_dma) begin
                st_d.cnt = shadow;
            end
        end
        if (dma_done) begin
            st_d.cnt = '0;
        end
        if (soft_rst) begin
            st_d = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign count    = st_q.cnt;
    assign dma_mode = st_q.dma;

    // R7
    done_zeroes_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dma_done |=> (count == '0));

    // R3
    plain_cmd_drops_dma_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !cmd_dma) |=> !dma_mode);

    // R3
    plain_cmd_keeps_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !cmd_dma && !dma_done && !soft_rst) |=> $stable(count));

endmodule

// File: rtl/tcnt_len.sv
module tcnt_len #(
    parameter int CNT_W     = 24,
    parameter int CMD_LIMIT = 32,
    parameter int ZERO_LEN  = 65536
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             soft_rst,
    input  logic             start,
    input  logic             collect,
    input  logic [CNT_W-1:0] raw_count,
    input  logic [CNT_W-1:0] remain,
    output logic [CNT_W-1:0] len,
    output logic             len_valid
);

    localparam logic [CNT_W-1:0] ZERO_VAL = CNT_W'(ZERO_LEN);
    localparam logic [CNT_W-1:0] CAP_CMD  = CNT_W'(CMD_LIMIT);

    typedef struct packed {
        logic [CNT_W-1:0] len;
        logic             vld;
        logic             coll;
    } state_t;

    state_t st_d, st_q;

    logic [CNT_W-1:0] eff_count;
    logic [CNT_W-1:0] cap;

    always_comb begin
        eff_count = (raw_count == '0) ? ZERO_VAL : raw_count;
        cap       = collect ? CAP_CMD : remain;
        st_d      = st_q;
        st_d.vld  = 1'b0;
        if (start) begin
            st_d.vld  = 1'b1;
            st_d.coll = collect;
            st_d.len  = (eff_count < cap) ? eff_count : cap;
        end
        if (soft_rst) begin
            st_d = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign len       = st_q.len;
    assign len_valid = st_q.vld;

    // R5
    collect_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (len_valid && st_q.coll) |-> (len <= CAP_CMD));

    // R5
    valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !soft_rst) |=> len_valid);

    // R4
    zero_count_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !soft_rst && raw_count == '0 && !collect && remain >= ZERO_VAL)
        |=> (len == ZERO_VAL));

endmodule

// File: rtl/tcnt_status.sv
module tcnt_status (
    input  logic clk,
    input  logic rst_n,
    input  logic soft_rst,
    input  logic count_wr,
    input  logic cause_rd,
    input  logic xfer_start,
    input  logic dma_done,
    output logic tc
);

    typedef struct packed {
        logic tc;
    } state_t;

    state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (count_wr || cause_rd || xfer_start) begin
            st_d.tc = 1'b0;
        end
        if (dma_done) begin
            st_d.tc = 1'b1;
        end
        if (soft_rst) begin
            st_d = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign tc = st_q.tc;

    // R6
    write_clears_tc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (count_wr && !dma_done) |=> !tc);

    // R8
    cause_clears_tc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((cause_rd || xfer_start) && !dma_done) |=> !tc);

    // R7
    done_sets_tc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dma_done && !soft_rst) |=> tc);

endmodule

// File: rtl/xfer_count_regs.sv
module xfer_count_regs #(
    parameter int          NBYTES    = 3,
    parameter int          BYTE_W    = 8,
    parameter int          CMD_LIMIT = 32,
    parameter int          ZERO_LEN  = 65536,
    parameter logic [7:0]  CHIP_ID   = 8'h12
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic [1:0]  wr_sel,
    input  logic [7:0]  wr_data,
    input  logic [1:0]  rd_sel,
    output logic [7:0]  rd_data,
    input  logic        cmd_valid,
    input  logic [1:0]  cmd_op,
    input  logic        cmd_dma,
    input  logic        dma_done,
    input  logic        cause_rd,
    input  logic        collect_mode,
    input  logic [23:0] remain,
    output logic [23:0] xfer_len,
    output logic        xfer_len_valid,
    output logic        term_count,
    output logic        dma_mode
);

    import tcnt_pkg::*;

    localparam int SEL_W = 2;
    localparam int CNT_W = NBYTES * BYTE_W;
    localparam logic [SEL_W-1:0] HI_SEL = SEL_W'(NBYTES - 1);

    cmd_op_e op;
    logic    soft_rst;
    logic    xfer_start;
    logic    count_wr;
    logic    hi_written;

    logic [NBYTES-1:0][BYTE_W-1:0] shadow;
    logic [NBYTES-1:0][BYTE_W-1:0] count;
    logic [CNT_W-1:0]              len_src;

    assign op         = cmd_op_e'(cmd_op);
    assign soft_rst   = cmd_valid && (op == OP_SRST);
    assign xfer_start = cmd_valid && (op == OP_XFER);
    assign count_wr   = wr_en && (wr_sel <= HI_SEL);
    assign len_src    = cmd_dma ? CNT_W'(shadow) : CNT_W'(count);

    tcnt_shadow #(.NBYTES(NBYTES), .BYTE_W(BYTE_W), .SEL_W(SEL_W)) u_shadow (
        .clk        (clk),
        .rst_n      (rst_n),
        .soft_rst   (soft_rst),
        .wr_en      (wr_en),
        .wr_sel     (wr_sel),
        .wr_data    (wr_data[BYTE_W-1:0]),
        .shadow     (shadow),
        .hi_written (hi_written)
    );

    tcnt_count #(.NBYTES(NBYTES), .BYTE_W(BYTE_W)) u_count (
        .clk       (clk),
        .rst_n     (rst_n),
        .soft_rst  (soft_rst),
        .cmd_valid (cmd_valid),
        .cmd_dma   (cmd_dma),
        .dma_done  (dma_done),
        .shadow    (shadow),
        .count     (count),
        .dma_mode  (dma_mode)
    );

    tcnt_len #(.CNT_W(CNT_W), .CMD_LIMIT(CMD_LIMIT), .ZERO_LEN(ZERO_LEN)) u_len (
        .clk       (clk),
        .rst_n     (rst_n),
        .soft_rst  (soft_rst),
        .start     (xfer_start),
        .collect   (collect_mode),
        .raw_count (len_src),
        .remain    (remain),
        .len       (xfer_len),
        .len_valid (xfer_len_valid)
    );

    tcnt_status u_status (
        .clk        (clk),
        .rst_n      (rst_n),
        .soft_rst   (soft_rst),
        .count_wr   (count_wr),
        .cause_rd   (cause_rd),
        .xfer_start (xfer_start),
        .dma_done   (dma_done),
        .tc         (term_count)
    );

    // Read mux: high select shows the identification byte until first written
    always_comb begin
        rd_data = '0;
        for (int i = 0; i < NBYTES; i++) begin
            if (rd_sel == SEL_W'(i)) begin
                rd_data = 8'(count[i]);
            end
        end
        if (rd_sel == HI_SEL && !hi_written) begin
            rd_data = CHIP_ID;
        end
    end

    // R9
    id_after_srst_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (soft_rst && rd_sel == HI_SEL) |=> (rd_sel != HI_SEL) || (rd_data == CHIP_ID));

endmodule

// File: tb/test_xfer_count_regs.sv
`timescale 1ns/1ps
module test_xfer_count_regs;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_sel = '0;
    logic [7:0]  wr_data = '0;
    logic [1:0]  rd_sel = '0;
    logic [7:0]  rd_data;
    logic        cmd_valid = 1'b0;
    logic [1:0]  cmd_op = '0;
    logic        cmd_dma = 1'b0;
    logic        dma_done = 1'b0;
    logic        cause_rd = 1'b0;
    logic        collect_mode = 1'b0;
    logic [23:0] remain = '0;
    logic [23:0] xfer_len;
    logic        xfer_len_valid;
    logic        term_count;
    logic        dma_mode;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    xfer_count_regs i_xfer_count_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .rd_sel(rd_sel), .rd_data(rd_data), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_dma(cmd_dma), .dma_done(dma_done), .cause_rd(cause_rd),
        .collect_mode(collect_mode), .remain(remain), .xfer_len(xfer_len),
        .xfer_len_valid(xfer_len_valid), .term_count(term_count), .dma_mode(dma_mode)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic rd_check(input string req, input logic [1:0] sel, input logic [7:0] exp);
        rd_sel = sel;
        #1;
        check(req, {24'h0, rd_data}, {24'h0, exp});
    endtask

    task automatic wr(input logic [1:0] sel, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = sel; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic cmd(input logic [1:0] op, input logic dma);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = op; cmd_dma = dma;
        @(negedge clk);
        cmd_valid = 1'b0; cmd_dma = 1'b0; cmd_op = 2'd0;
    endtask

    task automatic pulse_done();
        @(negedge clk);
        dma_done = 1'b1;
        @(negedge clk);
        dma_done = 1'b0;
    endtask

    task automatic xfer(input logic dma, input logic coll, input logic [23:0] rem,
                        input logic [23:0] exp, input string req);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = 2'd1; cmd_dma = dma; collect_mode = coll; remain = rem;
        @(negedge clk);
        cmd_valid = 1'b0; cmd_dma = 1'b0; cmd_op = 2'd0;
        check({req, " valid"}, {31'h0, xfer_len_valid}, 32'h1);
        check({req, " len"}, {8'h0, xfer_len}, {8'h0, exp});
        @(negedge clk);
        check({req, " pulse"}, {31'h0, xfer_len_valid}, 32'h0);
        collect_mode = 1'b0;
    endtask

    task automatic t_reset();
        rd_check("R1 lo", 2'd0, 8'h00);
        rd_check("R1 mid", 2'd1, 8'h00);
        rd_check("R1 id", 2'd2, 8'h12);
        check("R1 tc", {31'h0, term_count}, 32'h0);
        check("R1 dma", {31'h0, dma_mode}, 32'h0);
    endtask

    task automatic t_shadow_and_load();
        wr(2'd0, 8'h34);
        wr(2'd1, 8'h12);
        wr(2'd3, 8'hFF);
        rd_check("R2 lo held", 2'd0, 8'h00);
        rd_check("R9 id kept", 2'd2, 8'h12);
        cmd(2'd0, 1'b1);
        rd_check("R3 lo load", 2'd0, 8'h34);
        rd_check("R3 mid load", 2'd1, 8'h12);
        check("R3 dma set", {31'h0, dma_mode}, 32'h1);
        wr(2'd0, 8'h77);
        cmd(2'd0, 1'b0);
        check("R3 dma clr", {31'h0, dma_mode}, 32'h0);
        rd_check("R3 no copy", 2'd0, 8'h34);
    endtask

    task automatic t_lengths();
        // live count is 0x1234
        xfer(1'b0, 1'b0, 24'h000100, 24'h000100, "R5 remain cap");
        xfer(1'b0, 1'b0, 24'h005000, 24'h001234, "R4 count");
        xfer(1'b0, 1'b1, 24'hFFFFFF, 24'h000020, "R5 collect");
        wr(2'd0, 8'h00);
        wr(2'd1, 8'h00);
        wr(2'd2, 8'h02);
        rd_check("R9 hi written", 2'd2, 8'h00);
        xfer(1'b1, 1'b0, 24'hFFFFFF, 24'h020000, "R4 high byte");
        rd_check("R9 live hi", 2'd2, 8'h02);
        wr(2'd2, 8'h00);
        xfer(1'b1, 1'b0, 24'h020000, 24'h010000, "R4 zero");
        wr(2'd0, 8'h05);
        xfer(1'b1, 1'b0, 24'h000064, 24'h000005, "R5 fresh shadow");
    endtask

    task automatic t_status();
        pulse_done();
        check("R7 tc set", {31'h0, term_count}, 32'h1);
        rd_check("R7 count zero", 2'd0, 8'h00);
        wr(2'd1, 8'h01);
        check("R6 wr clr", {31'h0, term_count}, 32'h0);
        pulse_done();
        @(negedge clk); cause_rd = 1'b1;
        @(negedge clk); cause_rd = 1'b0;
        check("R8 cause clr", {31'h0, term_count}, 32'h0);
        pulse_done();
        xfer(1'b0, 1'b0, 24'h10, 24'h10, "R8 xfer");
        check("R8 xfer clr", {31'h0, term_count}, 32'h0);
        @(negedge clk); dma_done = 1'b1; cause_rd = 1'b1;
        @(negedge clk); dma_done = 1'b0; cause_rd = 1'b0;
        check("R7 set wins", {31'h0, term_count}, 32'h1);
    endtask

    task automatic t_soft_reset();
        wr(2'd0, 8'h55);
        cmd(2'd0, 1'b1);
        rd_check("R3 pre", 2'd0, 8'h55);
        cmd(2'd2, 1'b1);
        rd_check("R10 id back", 2'd2, 8'h12);
        rd_check("R10 count", 2'd0, 8'h00);
        check("R10 dma", {31'h0, dma_mode}, 32'h0);
        check("R10 tc", {31'h0, term_count}, 32'h0);
        cmd(2'd0, 1'b1);
        rd_check("R10 shadow", 2'd0, 8'h00);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_shadow_and_load();
        t_lengths();
        t_status();
        t_soft_reset();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule